// File: doc/BRIEF.md
# Per-Sector Lock Register Protection Unit

This unit guards a serial flash array split into 128 sectors of 64 KB each. Every sector owns a two-bit lock register: a write-protect bit and a freeze bit. The sector is picked from bits [22:16] of a 23-bit byte address, so any byte inside a sector reaches that sector's register. The command front end sends lock-register reads and writes here. The write/program/erase path asks this unit, for each modifying operation, whether the operation may go ahead.

A modifying operation is refused when the target sector's write-protect bit is set, or when the separate read-only-region decoder raises its protect flag for that address. The two protection schemes therefore combine as a logical OR.

Once a freeze bit is set, both bits of that sector are held against every later write until a power-up reset. The unit also holds the read-only-region configuration word. A hardware write-protect pin, together with a locking enable, can stop that word from being updated.

Top module: `sector_lock_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, every lock register reads 0, `bp_value` is 0, and `lr_done`, `lr_rdata`, `mod_grant` and `mod_fail` are all 0.
- R2: The sector index is address bits [22:16]. Two different byte addresses that share these bits select the same lock register.
- R3: A read request (`lr_rd_req`) produces, on the following cycle, a one-cycle `lr_done` pulse and `lr_rdata` = {6'b0, freeze, write-protect}, with write-protect in bit 0 and freeze in bit 1. In cycles that do not complete a read, `lr_rdata` is 0.
- R4: On an unfrozen sector, a write request stores `lr_wdata[0]` as write-protect and `lr_wdata[1]` as freeze. Bits 7:2 are ignored. `lr_done` pulses on the following cycle.
- R5: On a frozen sector (freeze = 1), a write request leaves both bits unchanged but still pulses `lr_done`.
- R6: A modify request (`mod_req`) aimed at a sector whose write-protect bit is 1 gives a one-cycle `mod_fail` on the next cycle and no `mod_grant`.
- R7: A modify request with `bp_protect` high is refused with `mod_fail` whatever the lock register holds.
- R8: A modify request that neither scheme protects gives a one-cycle `mod_grant` on the next cycle and no `mod_fail`.
- R9: When a lock write and a modify request or a lock read fall in the same cycle, the modify decision and the read data both use the lock state from before that write.
- R10: `bp_wr_req` loads `bp_wdata` into `bp_value` when `wp_n` is 1 or `hw_lock_en` is 0. When `wp_n` is 0 and `hw_lock_en` is 1, the update is dropped.
- R11: No command can clear a freeze bit. Only a reset releases it, after which the sector reads 0 and modify requests to it are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| lr_rd_req | input | 1 | Lock-register read request |
| lr_wr_req | input | 1 | Lock-register write request |
| lr_addr | input | 23 | Byte address selecting the lock register |
| lr_wdata | input | 8 | Write data: bit 0 write-protect, bit 1 freeze |
| lr_done | output | 1 | One-cycle completion pulse for a read or write |
| lr_rdata | output | 8 | Read data, valid with lr_done after a read |
| mod_req | input | 1 | Write/program/erase permission request |
| mod_addr | input | 23 | Byte address targeted by the modify request |
| bp_protect | input | 1 | Read-only-region decoder says the target is protected |
| mod_grant | output | 1 | One-cycle strobe allowing the array write |
| mod_fail | output | 1 | One-cycle pulse reporting a refused operation |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| hw_lock_en | input | 1 | Enables pin locking of the read-only-region settings |
| bp_wr_req | input | 1 | Request to update the read-only-region settings |
| bp_wdata | input | 4 | New read-only-region settings |
| bp_value | output | 4 | Current read-only-region settings |

## Verification
A lock-register write and a modify request can be accepted in the same clock edge, and so can a lock read and a lock write. The bench drives both pairs in one cycle on a single sector. It first writes write-protect = 1 while asking to modify that sector, and expects a grant, because the decision uses the old state. The next modify request must then fail. A combined read and write must return the value held before the write, and a separate read afterwards must show the new value.

// File: rtl/sector_lock_guard.sv
module sector_lock_guard #(
  parameter int ADDR_W  = 23,
  parameter int SEC_LSB = 16,
  parameter int SECTORS = 128,
  parameter int BP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_rd_req,
  input  logic              lr_wr_req,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic [7:0]        lr_wdata,
  output logic              lr_done,
  output logic [7:0]        lr_rdata,
  input  logic              mod_req,
  input  logic [ADDR_W-1:0] mod_addr,
  input  logic              bp_protect,
  output logic              mod_grant,
  output logic              mod_fail,
  input  logic              wp_n,
  input  logic              hw_lock_en,
  input  logic              bp_wr_req,
  input  logic [BP_W-1:0]   bp_wdata,
  output logic [BP_W-1:0]   bp_value
);
  localparam int SEC_W = $clog2(SECTORS);

  logic [SECTORS-1:0] wl_q, ld_q;
  logic [SEC_W-1:0]   lr_sec, mod_sec;
  logic               lr_frozen, mod_block, bp_open;

  assign lr_sec    = lr_addr[SEC_LSB +: SEC_W];
  assign mod_sec   = mod_addr[SEC_LSB +: SEC_W];
  assign lr_frozen = ld_q[lr_sec];
  assign mod_block = wl_q[mod_sec] | bp_protect;
  assign bp_open   = wp_n | ~hw_lock_en;

  logic unused_bits;
  assign unused_bits = ^{lr_addr[SEC_LSB-1:0], mod_addr[SEC_LSB-1:0], lr_wdata[7:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q      <= '0;
      ld_q      <= '0;
      lr_done   <= 1'b0;
      lr_rdata  <= '0;
      mod_grant <= 1'b0;
      mod_fail  <= 1'b0;
      bp_value  <= '0;
    end else begin
      if (lr_wr_req && !lr_frozen) begin
        wl_q[lr_sec] <= lr_wdata[0];
        ld_q[lr_sec] <= lr_wdata[1];
      end
      lr_done   <= lr_rd_req | lr_wr_req;
      lr_rdata  <= lr_rd_req ? {6'b0, ld_q[lr_sec], wl_q[lr_sec]} : 8'h00;
      mod_grant <= mod_req & ~mod_block;
      mod_fail  <= mod_req & mod_block;
      if (bp_wr_req && bp_open) bp_value <= bp_wdata;
    end
  end
endmodule

// File: rtl/sector_lock_guard_chk.sv
module sector_lock_guard_chk #(
  parameter int ADDR_W  = 23,
  parameter int SEC_LSB = 16,
  parameter int SECTORS = 128,
  parameter int BP_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lr_rd_req,
  input logic              lr_wr_req,
  input logic [ADDR_W-1:0] lr_addr,
  input logic              lr_done,
  input logic [7:0]        lr_rdata,
  input logic              mod_req,
  input logic [ADDR_W-1:0] mod_addr,
  input logic              bp_protect,
  input logic              mod_grant,
  input logic              mod_fail,
  input logic              wp_n,
  input logic              hw_lock_en,
  input logic [BP_W-1:0]   bp_value,
  input logic [SECTORS-1:0] wl_q,
  input logic [SECTORS-1:0] ld_q
);
  localparam int SEC_W = $clog2(SECTORS);

  p_done_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_rd_req || lr_wr_req) |=> lr_done);
  p_rdata_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lr_rdata[7:2] == 6'b0);
  p_frozen_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_wr_req && ld_q[lr_addr[SEC_LSB +: SEC_W]]) |=> ($stable(ld_q) && $stable(wl_q)));
  p_locked_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && wl_q[mod_addr[SEC_LSB +: SEC_W]]) |=> (mod_fail && !mod_grant));
  p_bp_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && bp_protect) |=> (mod_fail && !mod_grant));
  p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_grant || mod_fail) |-> $past(mod_req));
  p_grant_fail_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_grant && mod_fail));
  p_bp_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && hw_lock_en) |=> $stable(bp_value));
endmodule

bind sector_lock_guard sector_lock_guard_chk #(
  .ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SECTORS(SECTORS), .BP_W(BP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lr_rd_req(lr_rd_req), .lr_wr_req(lr_wr_req),
  .lr_addr(lr_addr), .lr_done(lr_done), .lr_rdata(lr_rdata), .mod_req(mod_req),
  .mod_addr(mod_addr), .bp_protect(bp_protect), .mod_grant(mod_grant),
  .mod_fail(mod_fail), .wp_n(wp_n), .hw_lock_en(hw_lock_en), .bp_value(bp_value),
  .wl_q(wl_q), .ld_q(ld_q)
);

// File: tb/sector_lock_guard_tb_top.sv
module sector_lock_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lr_rd_req = 0, lr_wr_req = 0, mod_req = 0, bp_protect = 0;
  logic [22:0] lr_addr = '0, mod_addr = '0;
  logic [7:0] lr_wdata = '0, lr_rdata;
  logic lr_done, mod_grant, mod_fail;
  logic wp_n = 1'b1, hw_lock_en = 1'b0, bp_wr_req = 1'b0;
  logic [3:0] bp_wdata = '0, bp_value;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sector_lock_guard dut_i (
    .clk(clk), .rst_n(rst_n), .lr_rd_req(lr_rd_req), .lr_wr_req(lr_wr_req),
    .lr_addr(lr_addr), .lr_wdata(lr_wdata), .lr_done(lr_done), .lr_rdata(lr_rdata),
    .mod_req(mod_req), .mod_addr(mod_addr), .bp_protect(bp_protect),
    .mod_grant(mod_grant), .mod_fail(mod_fail), .wp_n(wp_n), .hw_lock_en(hw_lock_en),
    .bp_wr_req(bp_wr_req), .bp_wdata(bp_wdata), .bp_value(bp_value)
  );

  function automatic logic [22:0] sa(input int sec, input logic [15:0] off);
    return {sec[6:0], off};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge with outputs settled.
  task automatic cyc(input logic rd, input logic wr, input logic [22:0] la, input logic [7:0] wd,
                     input logic mr, input logic [22:0] ma, input logic bpp);
    @(negedge clk);
    lr_rd_req = rd; lr_wr_req = wr; lr_addr = la; lr_wdata = wd;
    mod_req = mr; mod_addr = ma; bp_protect = bpp;
    @(negedge clk);
    lr_rd_req = 0; lr_wr_req = 0; mod_req = 0; bp_protect = 0;
  endtask

  task automatic rd_chk(input logic [22:0] a, input logic [7:0] exp, input string tag);
    cyc(1, 0, a, 8'h00, 0, '0, 0);
    chk(lr_done === 1'b1, tag, lr_done, 1);
    chk(lr_rdata === exp, tag, lr_rdata, exp);
  endtask

  task automatic mod_chk(input logic [22:0] a, input logic bpp, input logic exp_ok, input string tag);
    cyc(0, 0, '0, 8'h00, 1, a, bpp);
    chk(mod_grant === exp_ok && mod_fail === !exp_ok, tag, {mod_grant, mod_fail}, {exp_ok, !exp_ok});
  endtask

  task automatic t_reset;
    #5;
    chk(lr_done === 0 && mod_grant === 0 && mod_fail === 0, "R1 outputs in reset", {lr_done, mod_grant, mod_fail}, 0);
    chk(lr_rdata === 0 && bp_value === 0, "R1 data in reset", {lr_rdata, bp_value}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(lr_done === 0 && mod_grant === 0 && lr_rdata === 0, "R1 first cycle", {lr_done, mod_grant, lr_rdata}, 0);
    rd_chk(sa(0, 16'h0000), 8'h00, "R1 sector0 clear");
    rd_chk(sa(127, 16'hFFFF), 8'h00, "R1 sector127 clear");
  endtask

  task automatic t_rw_basic;
    cyc(0, 1, sa(5, 16'h0010), 8'hFD, 0, '0, 0);
    chk(lr_done === 1'b1, "R4 write done", lr_done, 1);
    chk(lr_rdata === 8'h00, "R3 rdata zero on write", lr_rdata, 0);
    rd_chk(sa(5, 16'hABCD), 8'h01, "R2 R4 other byte same sector");
    rd_chk(sa(4, 16'hFFFF), 8'h00, "R2 neighbour below");
    rd_chk(sa(6, 16'h0000), 8'h00, "R2 neighbour above");
    @(negedge clk);
    chk(lr_done === 0 && lr_rdata === 0, "R3 single-cycle pulse", {lr_done, lr_rdata}, 0);
  endtask

  task automatic t_modify;
    mod_chk(sa(5, 16'h1234), 0, 0, "R6 locked sector refused");
    mod_chk(sa(6, 16'h0000), 0, 1, "R8 free sector granted");
    @(negedge clk);
    chk(mod_grant === 0, "R8 grant single cycle", mod_grant, 0);
    mod_chk(sa(6, 16'h0000), 1, 0, "R7 region protect refused");
    cyc(0, 1, sa(5, 16'h0000), 8'h00, 0, '0, 0);
    mod_chk(sa(5, 16'hFFFF), 0, 1, "R4 R8 unlocked again granted");
  endtask

  task automatic t_lockdown;
    cyc(0, 1, sa(127, 16'h0000), 8'h03, 0, '0, 0);
    rd_chk(sa(127, 16'h8000), 8'h03, "R4 freeze set");
    cyc(0, 1, sa(127, 16'h0000), 8'h00, 0, '0, 0);
    chk(lr_done === 1'b1, "R5 write on frozen still done", lr_done, 1);
    rd_chk(sa(127, 16'h0001), 8'h03, "R5 R11 frozen unchanged");
    mod_chk(sa(127, 16'h0000), 0, 0, "R5 frozen locked refused");
    cyc(0, 1, sa(126, 16'h0000), 8'h02, 0, '0, 0);
    cyc(0, 1, sa(126, 16'h0000), 8'h01, 0, '0, 0);
    rd_chk(sa(126, 16'h0000), 8'h02, "R5 frozen open sector stays open");
    mod_chk(sa(126, 16'h0000), 0, 1, "R5 frozen open sector granted");
  endtask

  task automatic t_same_cycle;
    cyc(0, 1, sa(9, 16'h0000), 8'h01, 1, sa(9, 16'h0042), 0);
    chk(mod_grant === 1 && mod_fail === 0, "R9 modify uses old lock", {mod_grant, mod_fail}, 2);
    mod_chk(sa(9, 16'h0000), 0, 0, "R9 next modify sees new lock");
    cyc(1, 1, sa(9, 16'h0000), 8'h00, 0, '0, 0);
    chk(lr_rdata === 8'h01, "R9 read returns pre-write value", lr_rdata, 8'h01);
    rd_chk(sa(9, 16'h0000), 8'h00, "R9 write applied");
  endtask

  task automatic t_bp;
    @(negedge clk); hw_lock_en = 1; wp_n = 0; bp_wr_req = 1; bp_wdata = 4'hA;
    @(negedge clk); bp_wr_req = 0;
    chk(bp_value === 4'h0, "R10 update dropped when pin locked", bp_value, 0);
    @(negedge clk); wp_n = 1; bp_wr_req = 1; bp_wdata = 4'hA;
    @(negedge clk); bp_wr_req = 0;
    chk(bp_value === 4'hA, "R10 update with pin high", bp_value, 4'hA);
    @(negedge clk); hw_lock_en = 0; wp_n = 0; bp_wr_req = 1; bp_wdata = 4'h5;
    @(negedge clk); bp_wr_req = 0;
    chk(bp_value === 4'h5, "R10 update with locking off", bp_value, 4'h5);
    wp_n = 1;
  endtask

  task automatic t_power_up;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(bp_value === 0, "R1 bp cleared by reset", bp_value, 0);
    rst_n = 1;
    rd_chk(sa(127, 16'h0000), 8'h00, "R11 freeze released by reset");
    mod_chk(sa(127, 16'h0000), 0, 1, "R11 sector writable after reset");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rw_basic();
        t_modify();
        t_lockdown();
        t_same_cycle();
        t_bp();
        t_power_up();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule